// File: doc/BRIEF.md
# Write Invalidation and Sync Coordinator

This block keeps the caches of several bus masters coherent after a write. When memory reports that a write has completed, the coordinator takes the writer's identity and the written byte range. It asks every other master to drop that range from its cache. Once each of those masters has confirmed the drop, it tells the writer that its write can now be seen by all other masters.

All invalidate requests share one payload: a flag, a first-byte address, a length, and the writer's identity. Each master has its own valid/ready pair for invalidates, for acknowledges and for sync notices. Only one round runs at a time. While a round is in progress, the completed-write input is held off.

Top module: `wr_coherency_coord`

## Requirements
- R1: After reset, `wr_ready` is 1, and `inv_valid`, `ack_ready` and `sync_valid` are all zero.
- R2: Once a completed write is accepted, `inv_valid` is raised on the next cycle for every master except the one named by `wr_src`. The writer's bit is never raised.
- R3: While any `inv_valid` bit is high, `inv_all` is 1, which means every master except `inv_src` must invalidate. `inv_src`, `inv_addr` (first byte) and `inv_len` (byte count minus one) equal the accepted write's fields. They stay stable until the round ends, even if the write inputs change.
- R4: A master's `inv_valid` bit stays high until that master's `inv_ready` is seen high at a clock edge. The bit is low from the next cycle on. `inv_ready` from masters that are not addressed has no effect.
- R5: `wr_ready` is 0 from the cycle after a write is accepted until the cycle after the sync handshake. A write presented during that time is accepted only after the round ends.
- R6: `ack_ready` is high for a master only when its invalidate handshake has completed and its acknowledge is still outstanding. Acknowledges sent at other times have no effect. These include acknowledges sent before the invalidate, acknowledges from the writer, and repeated acknowledges.
- R7: `sync_valid` stays zero until every targeted master has acknowledged. It rises on the cycle after the last acknowledge handshake.
- R8: The sync notice raises only the writer's bit of `sync_valid`, with `sync_src` equal to the writer. It holds until the writer's `sync_ready` is seen at an edge. On the next cycle the block is idle with `wr_ready` high.
- R9: `sync_ready` from masters other than the writer does not end the sync notice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Completed write present |
| wr_ready | output | 1 | Coordinator idle, accepts a completed write |
| wr_src | input | SRC_W | Index of the writing master |
| wr_addr | input | ADDR_W | First byte written |
| wr_len | input | LEN_W | Bytes written minus one |
| inv_valid | output | NUM_MASTERS | Per-master invalidate request |
| inv_ready | input | NUM_MASTERS | Per-master invalidate accept |
| inv_all | output | 1 | 1: all masters except inv_src invalidate |
| inv_addr | output | ADDR_W | First byte to invalidate |
| inv_len | output | LEN_W | Bytes to invalidate minus one |
| inv_src | output | SRC_W | Writer index |
| ack_valid | input | NUM_MASTERS | Per-master invalidation done |
| ack_ready | output | NUM_MASTERS | Per-master acknowledge accept |
| sync_valid | output | NUM_MASTERS | Per-master sync notice |
| sync_ready | input | NUM_MASTERS | Per-master sync accept |
| sync_src | output | SRC_W | Writer whose write is now visible |

## Verification
The assertions check the following on every cycle:
- The writer's invalidate bit stays low.
- Invalidate and sync requests hold until their handshakes complete.
- The payload does not move during a round.
- An acknowledge is never offered to a master that still has an invalidate pending.
- The sync notice is one-hot on the writer and never overlaps a new write acceptance.

Only the bench scenarios can show the following:
- The exact cycle on which each stage advances.
- Acknowledges sent early, by the writer, or a second time are ignored.
- Stray sync accepts from other masters are ignored.
- A write held off during a round is taken later with its own payload.

// File: rtl/wr_coherency_coord.sv
module wr_coherency_coord #(
  parameter int NUM_MASTERS = 4,
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 12,
  localparam int SRC_W      = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [SRC_W-1:0]       wr_src,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [LEN_W-1:0]       wr_len,
  output logic [NUM_MASTERS-1:0] inv_valid,
  input  logic [NUM_MASTERS-1:0] inv_ready,
  output logic                   inv_all,
  output logic [ADDR_W-1:0]      inv_addr,
  output logic [LEN_W-1:0]       inv_len,
  output logic [SRC_W-1:0]       inv_src,
  input  logic [NUM_MASTERS-1:0] ack_valid,
  output logic [NUM_MASTERS-1:0] ack_ready,
  output logic [NUM_MASTERS-1:0] sync_valid,
  input  logic [NUM_MASTERS-1:0] sync_ready,
  output logic [SRC_W-1:0]       sync_src
);

  typedef enum logic [1:0] {S_IDLE, S_INV, S_WAIT_ACK, S_SYNC} state_t;

  state_t                 state;
  logic [NUM_MASTERS-1:0] inv_pend, ack_pend;
  logic [NUM_MASTERS-1:0] wr_sel, src_sel;
  logic [NUM_MASTERS-1:0] inv_hs, ack_hs;
  logic [NUM_MASTERS-1:0] inv_left, ack_left;
  logic [SRC_W-1:0]       src_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [LEN_W-1:0]       len_q;

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_sel
    assign wr_sel[i]  = (wr_src == SRC_W'(i));
    assign src_sel[i] = (src_q  == SRC_W'(i));
  end

  wire busy = (state == S_INV) || (state == S_WAIT_ACK);

  assign wr_ready   = (state == S_IDLE);
  assign inv_valid  = (state == S_INV) ? inv_pend : '0;
  assign ack_ready  = busy ? (ack_pend & ~inv_pend) : '0;
  assign sync_valid = (state == S_SYNC) ? src_sel : '0;

  assign inv_all  = 1'b1;
  assign inv_addr = addr_q;
  assign inv_len  = len_q;
  assign inv_src  = src_q;
  assign sync_src = src_q;

  assign inv_hs   = inv_valid & inv_ready;
  assign ack_hs   = ack_valid & ack_ready;
  assign inv_left = inv_pend & ~inv_hs;
  assign ack_left = ack_pend & ~ack_hs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      inv_pend <= '0;
      ack_pend <= '0;
      src_q    <= '0;
      addr_q   <= '0;
      len_q    <= '0;
    end else begin
      case (state)
        S_IDLE: if (wr_valid) begin
          src_q    <= wr_src;
          addr_q   <= wr_addr;
          len_q    <= wr_len;
          inv_pend <= ~wr_sel;
          ack_pend <= ~wr_sel;
          state    <= S_INV;
        end
        S_INV: begin
          inv_pend <= inv_left;
          ack_pend <= ack_left;
          if (inv_left == '0) state <= S_WAIT_ACK;
        end
        S_WAIT_ACK: begin
          ack_pend <= ack_left;
          if (ack_left == '0) state <= S_SYNC;
        end
        S_SYNC: if (|(sync_valid & sync_ready)) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wr_coherency_coord_chk.sv
module wr_coherency_coord_chk #(
  parameter int NUM_MASTERS = 4,
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 12,
  localparam int SRC_W      = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_valid,
  input logic                   wr_ready,
  input logic [SRC_W-1:0]       wr_src,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [LEN_W-1:0]       wr_len,
  input logic [NUM_MASTERS-1:0] inv_valid,
  input logic [NUM_MASTERS-1:0] inv_ready,
  input logic                   inv_all,
  input logic [ADDR_W-1:0]      inv_addr,
  input logic [LEN_W-1:0]       inv_len,
  input logic [SRC_W-1:0]       inv_src,
  input logic [NUM_MASTERS-1:0] ack_valid,
  input logic [NUM_MASTERS-1:0] ack_ready,
  input logic [NUM_MASTERS-1:0] sync_valid,
  input logic [NUM_MASTERS-1:0] sync_ready,
  input logic [SRC_W-1:0]       sync_src
);

  logic [NUM_MASTERS-1:0] src_bit, sync_bit;
  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_bit
    assign src_bit[i]  = (inv_src  == SRC_W'(i));
    assign sync_bit[i] = (sync_src == SRC_W'(i));
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (inv_valid == '0 && ack_ready == '0 && sync_valid == '0));

  p_writer_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid & src_bit) == '0);

  p_payload_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && $past(!wr_ready)) |->
      ($stable(inv_addr) && $stable(inv_len) && $stable(inv_src)));

  p_inv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    |(inv_valid & ~inv_ready) |=> (($past(inv_valid & ~inv_ready) & ~inv_valid) == '0));

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|inv_valid || |sync_valid) |-> !wr_ready);

  p_ack_after_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ready & inv_valid) == '0);

  p_sync_after_acks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    |sync_valid |-> (ack_ready == '0 && inv_valid == '0));

  p_sync_writer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    |sync_valid |-> ($onehot0(sync_valid) && sync_valid == sync_bit));

  p_sync_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|sync_valid && (sync_valid & sync_ready) == '0) |=> sync_valid == $past(sync_valid));

endmodule

bind wr_coherency_coord wr_coherency_coord_chk #(
  .NUM_MASTERS(NUM_MASTERS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/wr_coherency_coord_test.sv
module wr_coherency_coord_test;
  localparam int N = 4;
  localparam int AW = 32;
  localparam int LW = 12;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_ready;
  logic [1:0] wr_src = 0;
  logic [AW-1:0] wr_addr = 0;
  logic [LW-1:0] wr_len = 0;
  logic [N-1:0] inv_valid, inv_ready = 0;
  logic inv_all;
  logic [AW-1:0] inv_addr;
  logic [LW-1:0] inv_len;
  logic [1:0] inv_src, sync_src;
  logic [N-1:0] ack_valid = 0, ack_ready, sync_valid, sync_ready = 0;

  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  wr_coherency_coord #(.NUM_MASTERS(N), .ADDR_W(AW), .LEN_W(LW)) uut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 wr_ready", 64'(wr_ready), 1);
    chk("R1 inv_valid", 64'(inv_valid), 0);
    chk("R1 ack_ready", 64'(ack_ready), 0);
    chk("R1 sync_valid", 64'(sync_valid), 0);
  endtask

  task automatic t_slow_round();
    wr_valid = 1; wr_src = 1; wr_addr = 32'h1000; wr_len = 12'h03F;
    tick();
    wr_valid = 0;
    chk("R2 targets skip writer 1", 64'(inv_valid), 4'b1101);
    chk("R3 all flag", 64'(inv_all), 1);
    chk("R3 addr", 64'(inv_addr), 32'h1000);
    chk("R3 len", 64'(inv_len), 12'h03F);
    chk("R3 src", 64'(inv_src), 1);
    chk("R5 held off", 64'(wr_ready), 0);
    tick(); tick();
    chk("R4 held without ready", 64'(inv_valid), 4'b1101);
    inv_ready = 4'b0011;
    tick();
    chk("R4 master0 dropped, writer ready ignored", 64'(inv_valid), 4'b1100);
    chk("R6 ack only for invalidated master", 64'(ack_ready), 4'b0001);
    inv_ready = 4'b1111;
    tick();
    inv_ready = 0;
    chk("R4 all dropped", 64'(inv_valid), 0);
    chk("R6 acks open", 64'(ack_ready), 4'b1101);
    ack_valid = 4'b0010;
    tick();
    chk("R6 writer ack ignored", 64'(ack_ready), 4'b1101);
    ack_valid = 4'b0101;
    tick();
    chk("R6 two acks taken", 64'(ack_ready), 4'b1000);
    chk("R7 no sync before last ack", 64'(sync_valid), 0);
    ack_valid = 4'b0101;
    tick();
    chk("R6 repeated ack ignored", 64'(ack_ready), 4'b1000);
    ack_valid = 4'b1000;
    tick();
    ack_valid = 0;
    chk("R7 sync after last ack", 64'(sync_valid), 4'b0010);
    chk("R8 sync_src", 64'(sync_src), 1);
    sync_ready = 4'b1101;
    tick();
    chk("R9 other sync_ready ignored", 64'(sync_valid), 4'b0010);
    chk("R5 still held", 64'(wr_ready), 0);
    sync_ready = 4'b0010;
    tick();
    sync_ready = 0;
    chk("R8 idle after sync", 64'(wr_ready), 1);
    chk("R8 sync dropped", 64'(sync_valid), 0);
  endtask

  task automatic t_holdoff();
    wr_valid = 1; wr_src = 3; wr_addr = 32'hA000; wr_len = 12'h007;
    tick();
    wr_src = 2; wr_addr = 32'hB000; wr_len = 12'h0FF;
    chk("R2 targets skip writer 3", 64'(inv_valid), 4'b0111);
    chk("R5 second write held", 64'(wr_ready), 0);
    inv_ready = 4'b1111;
    tick();
    inv_ready = 0;
    chk("R3 addr stable under new input", 64'(inv_addr), 32'hA000);
    chk("R3 src stable", 64'(inv_src), 3);
    ack_valid = 4'b0111;
    tick();
    ack_valid = 0;
    chk("R8 sync to writer 3", 64'(sync_valid), 4'b1000);
    sync_ready = 4'b1000;
    tick();
    sync_ready = 0;
    chk("R5 ready again", 64'(wr_ready), 1);
    tick();
    wr_valid = 0;
    chk("R5 held write now taken", 64'(inv_valid), 4'b1011);
    chk("R3 new addr", 64'(inv_addr), 32'hB000);
    chk("R3 new len", 64'(inv_len), 12'h0FF);
    inv_ready = 4'b1111;
    tick();
    inv_ready = 0;
    ack_valid = 4'b1011;
    tick();
    ack_valid = 0;
    sync_ready = 4'b0100;
    chk("R8 sync to writer 2", 64'(sync_valid), 4'b0100);
    tick();
    sync_ready = 0;
    chk("R8 idle", 64'(wr_ready), 1);
  endtask

  task automatic t_early_ack();
    wr_valid = 1; wr_src = 0; wr_addr = 32'h40; wr_len = 12'h01F;
    tick();
    wr_valid = 0;
    chk("R2 targets skip writer 0", 64'(inv_valid), 4'b1110);
    ack_valid = 4'b1111;
    chk("R6 no ack before invalidate", 64'(ack_ready), 0);
    tick();
    inv_ready = 4'b1110;
    tick();
    inv_ready = 0;
    chk("R6 early acks were ignored", 64'(ack_ready), 4'b1110);
    chk("R7 no sync yet", 64'(sync_valid), 0);
    tick();
    ack_valid = 0;
    chk("R7 sync raised", 64'(sync_valid), 4'b0001);
    sync_ready = 4'b0001;
    tick();
    sync_ready = 0;
    chk("R8 idle", 64'(wr_ready), 1);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    t_reset();
    t_slow_round();
    t_holdoff();
    t_early_ack();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule